// File: doc/BRIEF.md
# Interrupt-Driven DMA Activation Router

This block sits between the on-chip peripheral interrupt flags and a multi-channel DMA engine. Each DMA channel names one interrupt source through a select field and carries two control bits: a channel enable and an ownership bit. An enabled channel captures a request on the rising edge of its source flag, whatever the CPU interrupt controller's own priorities are. A fixed-priority sequencer then issues one start pulse at a time and waits for the engine's transfer-done pulse before it issues the next. When the transfer ends, the block emits a one-cycle clear strobe toward the peripheral that raised the flag.

The ownership bit decides who sees the request. An owned source goes to the DMA alone and its flag is cleared by the transfer. An unowned source also reaches the CPU and transfer-controller path, and its flag is never cleared by the DMA. A disabled channel, for example one whose transfer count has run out, passes nothing to the DMA, and its source goes to the CPU path. A parameter mask picks out a group of sources (converter-end, transmit-empty, receive-full types) whose flags clear only when the transfer actually touched the peripheral's data register, as reported on a separate input. When several channels select one source, a single flag edge leaves each of them pending, and they are served in channel order.

The sequencer has two states. In `S_IDLE` it waits for a pending request. The GRANT transition goes from `S_IDLE` to `S_BUSY` when at least one enabled channel is pending, and it pulses that channel's start. The RELEASE transition goes from `S_BUSY` back to `S_IDLE` on transfer-done, and it issues the clear strobe if one is due.

Top module: `irq_dma_router`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ch_start`, `src_clr` and `cpu_req` are all zero when no flag is high.
- R2: `cpu_req[s]` follows `src_flag[s]` in the same cycle whenever no channel with enable=1 and ownership=1 selects source s.
- R3: `cpu_req[s]` stays low while `src_flag[s]` is high if at least one channel with enable=1 and ownership=1 selects s, even if no data-register access has yet occurred.
- R4: A rising edge of `src_flag[s]`, seen at clock edge k, leaves every enabled channel that selects s pending. When the sequencer is idle, the start pulse is visible in the cycle after edge k+1 and lasts one cycle.
- R5: At most one `ch_start` bit is high in any cycle, and among pending enabled channels the lowest index is granted first.
- R6: After a start, no further start is issued until `xfer_done` has been sampled high. The next start can appear at the earliest one cycle after the clear-strobe cycle.
- R7: When the active channel has ownership=1 and its source is outside the register-access mask, `src_clr` shows a one-cycle one-hot pulse on that source in the cycle after `xfer_done` is sampled.
- R8: For a source inside the register-access mask (bit s of REG_CLR_MASK = 1), the clear strobe is issued only if `data_acc` was high in some cycle from the first busy cycle up to and including the `xfer_done` cycle.
- R9: When the active channel has ownership=0, no clear strobe is issued at the end of its transfer.
- R10: A channel with enable=0 captures no request and drops any request it already holds, so it receives no start.
- R11: When several enabled channels select one source, one flag edge produces one start per channel, in ascending channel order, each after the previous transfer's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | NUM_SRC | Peripheral interrupt flags, level |
| ch_sel | input | NUM_CH*SEL_W | Per-channel source select, channel c in bits [c*SEL_W +: SEL_W] |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_own | input | NUM_CH | Per-channel ownership: 1 = DMA owns source flag |
| xfer_done | input | 1 | Pulse: active transfer finished |
| data_acc | input | 1 | Pulse: active transfer accessed source data register |
| ch_start | output | NUM_CH | One-cycle start pulse per channel |
| src_clr | output | NUM_SRC | One-cycle flag-clear strobe per source |
| cpu_req | output | NUM_SRC | Interrupt requests forwarded to CPU / transfer controller |

## Verification
The bench builds the block with its defaults: four channels, sixteen sources and a register-access mask covering sources 10 to 12. Channels 0 and 2 share source 5, channel 1 takes source 3 and channel 3 takes masked source 12. With this layout the shared-source ordering, the masked clear with and without a data access, the unowned and disabled routes to the CPU, and a pending request dropped while another transfer is busy can all be reached in short scenarios. A behavioural model with its own pending list is compared with every output on every cycle.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } seq_state_t;
endpackage

// File: rtl/dmar_pend.sv
module dmar_pend #(
    parameter int NUM_CH  = 4,
    parameter int NUM_SRC = 16,
    parameter int SEL_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_flag,
    input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         grant,
    output logic [NUM_CH-1:0]         pend
);
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] rise;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= src_flag;
    end

    assign rise = src_flag & ~flag_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SEL_W-1:0] sel_c;
        assign sel_c = ch_sel[c*SEL_W +: SEL_W];

        // a fresh edge wins over the grant that consumes the old request
        always_ff @(posedge clk) begin
            if (!rst_n)              pend[c] <= 1'b0;
            else if (!ch_en[c])      pend[c] <= 1'b0;
            else if (rise[sel_c])    pend[c] <= 1'b1;
            else if (grant[c])       pend[c] <= 1'b0;
        end

        p_dte_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |=> !pend[c]);
    end
endmodule

// File: rtl/dmar_fwd.sv
module dmar_fwd #(
    parameter int NUM_CH  = 4,
    parameter int NUM_SRC = 16,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0]        src_flag,
    input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         ch_own,
    output logic [NUM_SRC-1:0]        cpu_req
);
    logic [NUM_SRC-1:0] owned;

    always_comb begin
        owned = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c] && ch_own[c])
                owned[ch_sel[c*SEL_W +: SEL_W]] = 1'b1;
        end
    end

    assign cpu_req = src_flag & ~owned;
endmodule

// File: rtl/dmar_seq.sv
module dmar_seq
    import dmar_pkg::*;
#(
    parameter int                 NUM_CH       = 4,
    parameter int                 NUM_SRC      = 16,
    parameter int                 SEL_W        = 4,
    parameter int                 CH_W         = 2,
    parameter logic [NUM_SRC-1:0] REG_CLR_MASK = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         pend,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         ch_own,
    input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
    input  logic                      xfer_done,
    input  logic                      data_acc,
    output logic [NUM_CH-1:0]         grant,
    output logic [NUM_CH-1:0]         ch_start,
    output logic [NUM_SRC-1:0]        src_clr
);
    seq_state_t        state_q, state_d;
    logic [CH_W-1:0]   act_q, pick;
    logic              found;
    logic              acc_q;
    logic [SEL_W-1:0]  act_src;
    logic              clr_ok;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_CH-1:0] eligible;

    assign eligible = pend & ch_en;

    // fixed priority: scan downwards so the lowest index is kept
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (eligible[c]) begin
                found = 1'b1;
                pick  = CH_W'(c);
            end
        end
    end

    always_comb begin
        grant   = '0;
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (found) begin
                grant[pick] = 1'b1;
                state_d     = S_BUSY;
            end
            S_BUSY: if (xfer_done) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign act_src = ch_sel[act_q*SEL_W +: SEL_W];
    assign clr_ok  = ch_own[act_q] &&
                     (!REG_CLR_MASK[act_src] || acc_q || data_acc);

    always_comb begin
        clr_vec          = '0;
        clr_vec[act_src] = 1'b1;
    end

    // state register and transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            act_q   <= '0;
            acc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                acc_q <= 1'b0;
                if (found) act_q <= pick;
            end else if (xfer_done) begin
                acc_q <= 1'b0;
            end else if (data_acc) begin
                acc_q <= 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_start <= '0;
            src_clr  <= '0;
        end else begin
            ch_start <= grant;
            src_clr  <= (state_q == S_BUSY && xfer_done && clr_ok) ? clr_vec : '0;
        end
    end

    p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));
    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && !xfer_done) |=> (ch_start == '0));
    p_clr_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr != '0) |-> $past(xfer_done));
    p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_clr));
    p_unowned_no_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && xfer_done && !ch_own[act_q]) |=> (src_clr == '0));
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
    parameter int                 NUM_CH       = 4,
    parameter int                 NUM_SRC      = 16,
    parameter int                 SEL_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter logic [NUM_SRC-1:0] REG_CLR_MASK = 16'h1C00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_flag,
    input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         ch_own,
    input  logic                      xfer_done,
    input  logic                      data_acc,
    output logic [NUM_CH-1:0]         ch_start,
    output logic [NUM_SRC-1:0]        src_clr,
    output logic [NUM_SRC-1:0]        cpu_req
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] grant;

    dmar_pend #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_flag (src_flag),
        .ch_sel   (ch_sel),
        .ch_en    (ch_en),
        .grant    (grant),
        .pend     (pend)
    );

    dmar_seq #(
        .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W),
        .CH_W(CH_W), .REG_CLR_MASK(REG_CLR_MASK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .ch_en     (ch_en),
        .ch_own    (ch_own),
        .ch_sel    (ch_sel),
        .xfer_done (xfer_done),
        .data_acc  (data_acc),
        .grant     (grant),
        .ch_start  (ch_start),
        .src_clr   (src_clr)
    );

    dmar_fwd #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_fwd (
        .src_flag (src_flag),
        .ch_sel   (ch_sel),
        .ch_en    (ch_en),
        .ch_own   (ch_own),
        .cpu_req  (cpu_req)
    );

    p_start_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |-> $past((pend & ch_en) != '0));
endmodule

// File: tb/irq_dma_router_tb.sv
module irq_dma_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int NSRC = 16;
    localparam int SW   = 4;
    localparam logic [NSRC-1:0] MASK = 16'h1C00;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_flag = '0;
    logic [NCH*SW-1:0] ch_sel = {4'd12, 4'd5, 4'd3, 4'd5};
    logic [NCH-1:0]  ch_en = '1;
    logic [NCH-1:0]  ch_own = '1;
    logic            xfer_done = 1'b0;
    logic            data_acc = 1'b0;
    logic [NCH-1:0]  ch_start;
    logic [NSRC-1:0] src_clr;
    logic [NSRC-1:0] cpu_req;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dma_router dut_i (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .ch_sel(ch_sel),
        .ch_en(ch_en), .ch_own(ch_own), .xfer_done(xfer_done),
        .data_acc(data_acc), .ch_start(ch_start), .src_clr(src_clr),
        .cpu_req(cpu_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit              m_pend [NCH];
    bit              m_busy;
    int              m_act;
    bit              m_acc;
    bit [NSRC-1:0]   m_prev;
    bit [NCH-1:0]    e_start;
    bit [NSRC-1:0]   e_clr;

    function automatic int sel_of(input int c);
        return int'(ch_sel[c*SW +: SW]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pend[c]) m_pend[c] = 0;
            m_busy = 0; m_act = 0; m_acc = 0; m_prev = '0;
            e_start = '0; e_clr = '0;
        end else begin
            int g;
            g = -1;
            e_start = '0;
            e_clr = '0;
            if (!m_busy) begin
                for (int c = 0; c < NCH; c++)
                    if (g < 0 && m_pend[c] && ch_en[c]) g = c;
                if (g >= 0) begin
                    e_start[g] = 1'b1;
                    m_busy = 1; m_act = g; m_acc = 0;
                end
            end else begin
                if (data_acc) m_acc = 1;
                if (xfer_done) begin
                    int s;
                    s = sel_of(m_act);
                    if (ch_own[m_act] && (!MASK[s] || m_acc)) e_clr[s] = 1'b1;
                    m_busy = 0;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                int s;
                s = sel_of(c);
                if (!ch_en[c]) m_pend[c] = 0;
                else if (src_flag[s] && !m_prev[s]) m_pend[c] = 1;
                else if (g == c) m_pend[c] = 0;
            end
            m_prev = src_flag;
        end
    end

    // compare every cycle, away from both edges' input changes
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            bit [NSRC-1:0] e_cpu;
            e_cpu = src_flag;
            for (int c = 0; c < NCH; c++)
                if (ch_en[c] && ch_own[c]) e_cpu[sel_of(c)] = 1'b0;
            chk("R5 start per cycle", 32'(ch_start), 32'(e_start));
            chk("R7 clear per cycle", 32'(src_clr), 32'(e_clr));
            chk("R2 cpu per cycle", 32'(cpu_req), 32'(e_cpu));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic done_pulse(input bit acc);
        @(negedge clk);
        xfer_done = 1'b1;
        data_acc  = acc;
        @(negedge clk);
        xfer_done = 1'b0;
        data_acc  = 1'b0;
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        #2;
        chk("R1 start in reset", 32'(ch_start), 0);
        chk("R1 clear in reset", 32'(src_clr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1 start after reset", 32'(ch_start), 0);
        chk("R1 cpu after reset", 32'(cpu_req), 0);

        // shared source 5 on channels 0 and 2
        @(negedge clk);
        src_flag[5] = 1'b1;
        @(negedge clk); #2;
        chk("R4 no start after one edge", 32'(ch_start), 0);
        chk("R3 owned source hidden", 32'(cpu_req[5]), 0);
        @(negedge clk); #2;
        chk("R4 start ch0", 32'(ch_start), 32'h1);
        tick(3); #2;
        chk("R6 no start while busy", 32'(ch_start), 0);
        done_pulse(1'b0);
        chk("R7 clear source 5", 32'(src_clr), 32'h0020);
        src_flag[5] = 1'b0;
        @(negedge clk); #2;
        chk("R11 second sharer ch2", 32'(ch_start), 32'h4);
        done_pulse(1'b0);
        chk("R11 ch2 end clear", 32'(src_clr), 32'h0020);

        // masked source 12 on channel 3
        @(negedge clk);
        src_flag[12] = 1'b1;
        tick(2); #2;
        chk("R4 start ch3", 32'(ch_start), 32'h8);
        done_pulse(1'b0);
        chk("R8 no clear without access", 32'(src_clr), 0);
        chk("R3 masked owned hidden", 32'(cpu_req[12]), 0);
        @(negedge clk);
        src_flag[12] = 1'b0;
        @(negedge clk);
        src_flag[12] = 1'b1;
        tick(2); #2;
        chk("R8 restart ch3", 32'(ch_start), 32'h8);
        @(negedge clk);
        data_acc = 1'b1;
        @(negedge clk);
        data_acc = 1'b0;
        tick(2);
        done_pulse(1'b0);
        chk("R8 clear after access", 32'(src_clr), 32'h1000);
        src_flag[12] = 1'b0;

        // unowned channel 1
        @(negedge clk);
        ch_own[1] = 1'b0;
        src_flag[3] = 1'b1;
        #2;
        chk("R9 unowned reaches cpu", 32'(cpu_req[3]), 1);
        tick(2); #2;
        chk("R2 unowned still starts", 32'(ch_start), 32'h2);
        done_pulse(1'b0);
        chk("R9 no clear when unowned", 32'(src_clr), 0);
        src_flag[3] = 1'b0;
        ch_own[1] = 1'b1;

        // disabled channels
        @(negedge clk);
        ch_en[0] = 1'b0;
        ch_en[2] = 1'b0;
        src_flag[5] = 1'b1;
        #2;
        chk("R10 disabled source to cpu", 32'(cpu_req[5]), 1);
        tick(4); #2;
        chk("R10 no start when disabled", 32'(ch_start), 0);
        src_flag[5] = 1'b0;
        ch_en = '1;

        // pending dropped while another channel is busy
        @(negedge clk);
        src_flag[3] = 1'b1;
        tick(2); #2;
        chk("R4 start ch1", 32'(ch_start), 32'h2);
        @(negedge clk);
        src_flag[5] = 1'b1;
        tick(2);
        ch_en[0] = 1'b0;
        ch_en[2] = 1'b0;
        @(negedge clk);
        ch_en = '1;
        done_pulse(1'b1);
        chk("R7 clear source 3", 32'(src_clr), 32'h0008);
        src_flag[3] = 1'b0;
        tick(3); #2;
        chk("R10 dropped request not served", 32'(ch_start), 0);
        src_flag[5] = 1'b0;

        // two sources at once, three channels
        @(negedge clk);
        src_flag[3] = 1'b1;
        src_flag[5] = 1'b1;
        tick(2); #2;
        chk("R5 first ch0", 32'(ch_start), 32'h1);
        done_pulse(1'b0);
        @(negedge clk); #2;
        chk("R5 then ch1", 32'(ch_start), 32'h2);
        done_pulse(1'b0);
        @(negedge clk); #2;
        chk("R5 then ch2", 32'(ch_start), 32'h4);
        done_pulse(1'b0);
        src_flag = '0;
        tick(3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule